// File: doc/BRIEF.md
# Pipelined Dot-Product Multiply-Accumulate Engine

The engine computes the dot product of two signed 16-bit vectors that sit in two local memories. A start strobe supplies two base addresses and a length. The engine then walks both memories in step, one element per clock. Each element is read from a synchronous memory port and latched into an operand register. A product register separates the multiplier from the 40-bit accumulator.

After a short preload, every loop cycle does four things in parallel: it forms a product, adds the previous product into the sum, loads new operands and issues the next read. The sum therefore trails the products by one stage. A drain cycle after the loop adds the last product. A one-cycle done pulse then marks the result as valid.

The memory ports have a fixed read latency of one clock and carry no back-pressure. Data returned in the cycle after a read enable is always consumed, so the engine sustains one multiply-accumulate per clock without stalls. Control and status pins are plain levels and pulses.

Top module: `dotmac_engine`

## Requirements
- R1: While reset is held and after it is released, `done` is 0, both read enables are 0 and `result` is 0.
- R2: For each accepted start, each memory receives reads at the base address and then at consecutive addresses, incrementing by one per read and wrapping modulo 2^AW.
- R3: Elements are 16-bit two's complement. Each full 32-bit product is sign-extended into a 40-bit signed accumulator, so `result` equals the exact sum of the N products for any N up to 255.
- R4: The sum is cleared at the start of each operation, so no earlier result contributes to a new one.
- R5: For N ≥ 1, `done` is high for exactly one cycle. Counting the rising edge that samples `start` as edge 1, `done` rises on edge N+4, which means the loop adds one clock per product.
- R6: From `done` until the next accepted start, `result` holds its value.
- R7: A `start` that arrives while an operation is in progress is ignored. It causes no extra `done` and does not change the running result.
- R8: A length of 0 yields `result` = 0, with `done` high after edge 1 and no memory reads.
- R9: Each operation issues exactly N reads on each memory port and never more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only while idle |
| base_x | input | AW (8) | First address of vector X |
| base_y | input | AW (8) | First address of vector Y |
| length | input | LW (8) | Number of products N |
| x_rd_en | output | 1 | Read enable, X memory |
| x_addr | output | AW (8) | Read address, X memory |
| x_rdata | input | DW (16) | X read data, valid one clock after the enable |
| y_rd_en | output | 1 | Read enable, Y memory |
| y_addr | output | AW (8) | Read address, Y memory |
| y_rdata | input | DW (16) | Y read data, valid one clock after the enable |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | ACCW (40) | Signed accumulated dot product |

## Verification
The engine is exercised with lengths of 0, 1, 2 and 10 over ramp data. Lengths 1 and 2 expose off-by-one errors in the preload and drain steps that a long vector would hide. Mixed-sign extremes and a 200-element run of -32768 × -32768 separate a correct 40-bit sign-extended sum from a truncated or zero-extended one. A base address near the top of memory checks address wrap. A second start issued mid-operation, and a short run after a large one, distinguish ignored strobes and a proper accumulator clear from leaked state.

// File: rtl/dotmac_pkg.sv
package dotmac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PRELOAD,
    ST_LOOP,
    ST_DRAIN
  } mac_state_e;
endpackage

// File: rtl/dotmac_ptr.sv
module dotmac_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] INC = AW'(1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= base;
    else if (step) addr_q <= addr_q + INC;
  end

  assign addr = addr_q;
endmodule

// File: rtl/dotmac_ctrl.sv
module dotmac_ctrl
  import dotmac_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] length,
  output mac_state_e    state,
  output logic          ptr_load,
  output logic          rd_en,
  output logic          ld_feed,
  output logic          mul_en,
  output logic          acc_clr,
  output logic          acc_add,
  output logic          done
);
  localparam logic [LW-1:0] ONE = LW'(1);

  mac_state_e    state_q;
  logic [LW-1:0] fetch_left;
  logic [LW-1:0] loop_left;
  logic          done_q;

  always_comb begin
    ptr_load = (state_q == ST_IDLE) && start;
    rd_en    = ((state_q == ST_FETCH) || (state_q == ST_PRELOAD) ||
                (state_q == ST_LOOP)) && (fetch_left != '0);
    ld_feed  = (state_q == ST_PRELOAD) ||
               ((state_q == ST_LOOP) && (loop_left > ONE));
    mul_en   = (state_q == ST_LOOP);
    acc_clr  = (state_q == ST_PRELOAD) || (ptr_load && (length == '0));
    acc_add  = (state_q == ST_LOOP) || (state_q == ST_DRAIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fetch_left <= '0;
      loop_left  <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rd_en) fetch_left <= fetch_left - ONE;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            fetch_left <= length;
            loop_left  <= length;
            if (length == '0) done_q  <= 1'b1;
            else              state_q <= ST_FETCH;
          end
        end
        ST_FETCH:   state_q <= ST_PRELOAD;
        ST_PRELOAD: state_q <= ST_LOOP;
        ST_LOOP: begin
          loop_left <= loop_left - ONE;
          if (loop_left == ONE) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state = state_q;
  assign done  = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5

  AST_LOOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && loop_left == ONE) |=> state_q == ST_DRAIN); // R5
endmodule

// File: rtl/dotmac_datapath.sv
module dotmac_datapath #(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_feed,
  input  logic signed [DW-1:0]   x_rdata,
  input  logic signed [DW-1:0]   y_rdata,
  input  logic                   mul_en,
  input  logic                   acc_clr,
  input  logic                   acc_add,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW  = 2 * DW;
  localparam int EXT = ACCW - PW;

  logic signed [DW-1:0]   x_q, y_q;
  logic signed [PW-1:0]   prod_c, prod_q;
  logic signed [ACCW-1:0] prod_ext, acc_q;

  assign prod_c   = PW'(x_q) * PW'(y_q);
  assign prod_ext = {{EXT{prod_q[PW-1]}}, prod_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (ld_feed) begin
      x_q <= x_rdata;
      y_q <= y_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || acc_clr) prod_q <= '0;
    else if (mul_en)       prod_q <= prod_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || acc_clr) acc_q <= '0;
    else if (acc_add)      acc_q <= acc_q + prod_ext;
  end

  assign acc = acc_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_q == '0)); // R4
endmodule

// File: rtl/dotmac_engine.sv
module dotmac_engine
  import dotmac_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int LW   = 8,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          base_x,
  input  logic [AW-1:0]          base_y,
  input  logic [LW-1:0]          length,
  output logic                   x_rd_en,
  output logic [AW-1:0]          x_addr,
  input  logic signed [DW-1:0]   x_rdata,
  output logic                   y_rd_en,
  output logic [AW-1:0]          y_addr,
  input  logic signed [DW-1:0]   y_rdata,
  output logic                   done,
  output logic signed [ACCW-1:0] result
);
  localparam logic [AW-1:0] INC = AW'(1);

  mac_state_e state;
  logic ptr_load, rd_en, ld_feed, mul_en, acc_clr, acc_add;

  dotmac_ctrl #(.LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .length(length),
    .state(state), .ptr_load(ptr_load), .rd_en(rd_en), .ld_feed(ld_feed),
    .mul_en(mul_en), .acc_clr(acc_clr), .acc_add(acc_add), .done(done)
  );

  dotmac_ptr #(.AW(AW)) u_ptr_x (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .base(base_x),
    .step(rd_en), .addr(x_addr)
  );

  dotmac_ptr #(.AW(AW)) u_ptr_y (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .base(base_y),
    .step(rd_en), .addr(y_addr)
  );

  dotmac_datapath #(.DW(DW), .ACCW(ACCW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ld_feed(ld_feed),
    .x_rdata(x_rdata), .y_rdata(y_rdata), .mul_en(mul_en),
    .acc_clr(acc_clr), .acc_add(acc_add), .acc(result)
  );

  assign x_rd_en = rd_en;
  assign y_rd_en = rd_en;

  logic [LW:0]   rd_seen;
  logic [LW-1:0] len_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_seen <= '0;
      len_lat <= '0;
    end else if (ptr_load) begin
      rd_seen <= '0;
      len_lat <= length;
    end else if (x_rd_en) begin
      rd_seen <= rd_seen + 1'b1;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (x_rd_en && $past(x_rd_en)) |-> (x_addr == $past(x_addr) + INC)); // R2

  AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_seen <= {1'b0, len_lat}); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> $stable(result)); // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start) |=> (state != ST_FETCH)); // R7
endmodule

// File: tb/dotmac_engine_test.sv
module dotmac_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] base_x = '0, base_y = '0, length = '0;
  logic x_rd_en, y_rd_en, done;
  logic [7:0] x_addr, y_addr;
  logic signed [15:0] x_rdata = '0, y_rdata = '0;
  logic signed [39:0] result;

  logic signed [15:0] memx [0:255];
  logic signed [15:0] memy [0:255];

  typedef struct {
    longint val;
    int     n;
    int     due;
    int     rd0;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_fail = 0, cyc = 0, nrd = 0, ndone = 0, npush = 0;
  bit prev_done = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dotmac_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_x(base_x), .base_y(base_y),
    .length(length), .x_rd_en(x_rd_en), .x_addr(x_addr), .x_rdata(x_rdata),
    .y_rd_en(y_rd_en), .y_addr(y_addr), .y_rdata(y_rdata),
    .done(done), .result(result)
  );

  always @(posedge clk) begin
    cyc++;
    if (x_rd_en) begin
      nrd++;
      x_rdata <= memx[x_addr];
    end
    if (y_rd_en) y_rdata <= memy[y_addr];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R5 done wider than one cycle", 1, 0);
      if (done) begin
        ndone++;
        if (sb_q.size() == 0) chk(1'b0, "R7 unexpected done", 1, 0);
        else begin
          e = sb_q.pop_front();
          chk(result == e.val[39:0], "R3 R4 result", longint'(result), e.val);
          chk(cyc == e.due, (e.n == 0) ? "R8 done timing" : "R5 done timing", cyc, e.due);
          chk((nrd - e.rd0) == e.n, "R9 read count", nrd - e.rd0, e.n);
        end
      end
      prev_done = done;
    end
  end

  // Driver: computes the expected sum, pushes it, pulses start
  task automatic launch(input int bx, input int by, input int n, input bit push);
    exp_t e;
    longint s = 0;
    for (int i = 0; i < n; i++)
      s += longint'(memx[8'(bx + i)]) * longint'(memy[8'(by + i)]);
    e.val = s;
    e.n   = n;
    e.due = (n == 0) ? cyc + 1 : cyc + n + 4;
    e.rd0 = nrd;
    if (push) begin
      sb_q.push_back(e);
      npush++;
    end
    start  = 1'b1;
    base_x = 8'(bx);
    base_y = 8'(by);
    length = 8'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op(input int bx, input int by, input int n);
    longint s = 0;
    for (int i = 0; i < n; i++)
      s += longint'(memx[8'(bx + i)]) * longint'(memy[8'(by + i)]);
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(result == s[39:0], "R6 result held", longint'(result), s);
    end
  endtask

  task automatic fill_ramp();
    for (int i = 0; i < 256; i++) begin
      memx[i] = 16'(i * 37 - 4000);
      memy[i] = 16'(1500 - i * 13);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R5: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    fill_ramp();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 0 && x_rd_en == 0 && y_rd_en == 0, "R1 outputs idle in reset", done, 0);
    chk(result == 0, "R1 result zero in reset", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && x_rd_en == 0 && result == 0, "R1 outputs idle after reset", done, 0);

    // R2 R3 R5: ten-element ramp
    launch(3, 40, 10, 1'b1);   finish_op(3, 40, 10);
    // R5: single and double element, preload/drain edges
    launch(100, 7, 1, 1'b1);   finish_op(100, 7, 1);
    launch(20, 21, 2, 1'b1);   finish_op(20, 21, 2);
    // R2: addresses wrap past the top of memory
    launch(250, 251, 12, 1'b1); finish_op(250, 251, 12);

    // R3: mixed-sign extremes
    memx[0] = -16'sd32768; memy[0] = 16'sd32767;
    memx[1] = 16'sd32767;  memy[1] = 16'sd32767;
    memx[2] = -16'sd32768; memy[2] = -16'sd32768;
    memx[3] = -16'sd1;     memy[3] = 16'sd5;
    launch(0, 0, 4, 1'b1); finish_op(0, 0, 4);

    // R3: long sum that needs the 40-bit accumulator
    for (int i = 0; i < 200; i++) begin
      memx[i] = -16'sd32768;
      memy[i] = -16'sd32768;
    end
    launch(0, 0, 200, 1'b1); finish_op(0, 0, 200);

    // R4: short run after a large result starts from zero
    fill_ramp();
    launch(5, 5, 1, 1'b1); finish_op(5, 5, 1);

    // R8: zero length
    launch(9, 9, 0, 1'b1); finish_op(9, 9, 0);

    // R7: second start while busy is ignored
    launch(30, 60, 15, 1'b1);
    repeat (4) @(negedge clk);
    start = 1'b1; base_x = 8'd0; base_y = 8'd0; length = 8'd3;
    @(negedge clk);
    start = 1'b0;
    finish_op(30, 60, 15);
    repeat (20) @(negedge clk);
    chk(ndone == npush, "R7 done count", ndone, npush);

    // back-to-back operations
    launch(70, 80, 6, 1'b1); finish_op(70, 80, 6);
    launch(1, 2, 3, 1'b1);   finish_op(1, 2, 3);

    summary();
    $finish;
  end
endmodule